// File: doc/BRIEF.md
# UART Line Status and Break Unit

This block builds the 8-bit line status word of a 16550-style serial port and handles the receive break condition. It samples the receive line on each 16x oversample tick. When the line stays low for longer than one whole frame, it puts a single zero character, marked as a break, into its receive queue. It then holds off reception until the line has been idle high for half a bit. Characters that the deserialiser hands over carry their own parity and framing error bits. These bits travel with the character through the queue and show in the status word only while that character sits at the head.

The unit also follows how full the transmit holding store and the shift register are, and from that it derives the two transmitter-empty flags. A host read of the status word acknowledges the error flags as one step, without losing an error that arrives in the same cycle. A mode input picks between a single-entry legacy mode and a queued mode of `DEPTH` entries. The frame shape (5 to 8 data bits, optional parity, one or two stop bits) is set by static configuration inputs, which change only while the port is idle.

Top module: `uart_line_status`

## Requirements
- R1: With `tick16` high, a break is detected on the tick at which `rxd` has been low for F+1 consecutive ticks, where F = 16 x (1 start + (5 + `word_len`) data + `parity_en` + 1 + `stop2` stop) ticks. After F low ticks nothing has been pushed.
- R2: A break pushes exactly one character, with data 0x00 and the break tag, however long the line stays low. `rx_enable` goes low on the same edge.
- R3: After a break, `rx_enable` returns high only once `rxd` has been high for 8 consecutive ticks, and a low tick restarts that count. While `rx_enable` is low, `rx_char_valid` is ignored.
- R4: Status bits 2 (parity), 3 (framing) and 4 (break) show the error tags of the character at the queue head only. Popping with `rx_pop` brings up the tags of the next character.
- R5: A pulse on `lsr_rd` hides the head's bits 2 to 4 until a different character becomes head. It also clears bit 1 (overrun).
- R6: An error that arrives in the same cycle as `lsr_rd` stays visible. This holds both for a new head with an error tag and for a new overrun.
- R7: A push into a full store sets bit 1. In queued mode (`fifo_mode`=1) the new character is discarded. In legacy mode the single held character is replaced.
- R8: Bit 5 is 1 when the transmit store is empty. It is 0 from the cycle after `thr_wr` until `tsr_load` has taken the last stored byte.
- R9: Bit 6 is 1 only when the transmit store is empty and the shift register is idle. `tsr_load` with data makes the shift register busy, and `tsr_done` makes it idle.
- R10: Bit 7 is always 0 in legacy mode. In queued mode it is 1 while any queued character carries a tag, whether or not `lsr_rd` has been pulsed.
- R11: `lsi_irq` is high exactly when `lsi_en` is high and any of status bits 1 to 4 is set.
- R12: Bit 0 is 1 while the receive store holds a character. After reset the status word is 0x60, `rx_enable` is 1 and `rx_head_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = queued mode, 0 = single-entry legacy mode |
| tick16 | input | 1 | 16x oversample enable |
| rxd | input | 1 | Receive serial line, already synchronised |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present in frame |
| stop2 | input | 1 | Two stop bits |
| rx_char_valid | input | 1 | Deserialiser delivers a character |
| rx_char_data | input | 8 | Delivered character |
| rx_perr | input | 1 | Parity error tag of delivered character |
| rx_ferr | input | 1 | Framing error tag of delivered character |
| rx_pop | input | 1 | Host reads the head character |
| lsr_rd | input | 1 | Host reads the status word |
| thr_wr | input | 1 | Host writes a transmit byte |
| tsr_load | input | 1 | Shift register takes a byte from the transmit store |
| tsr_done | input | 1 | Shift register finished sending |
| lsi_en | input | 1 | Line status interrupt enable |
| lsr | output | 8 | Status word |
| rx_head_data | output | 8 | Head character, 0 when empty |
| rx_enable | output | 1 | Character reception permitted |
| lsi_irq | output | 1 | Line status interrupt |

## Verification
Break timing is tried with two frame shapes (10 and 9 bits). The detect edge is probed one tick short of the limit and at the limit, which tells a strict "longer than" apart from "at least". Recovery is tried with a glitch part way through the idle run, which tells a consecutive-tick count apart from a total count. A clean, a parity-tagged and a framing-tagged character are queued in turn, with a status read between pops, to show that the tags follow their character and that bit 7 outlives the read. Full-store pushes and reads in the same cycle as errors tell discard from overwrite and check that a status read keeps new errors.

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       stop2,
  input  logic       rx_char_valid,
  input  logic [7:0] rx_char_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_pop,
  input  logic       lsr_rd,
  input  logic       thr_wr,
  input  logic       tsr_load,
  input  logic       tsr_done,
  input  logic       lsi_en,
  output logic [7:0] lsr,
  output logic [7:0] rx_head_data,
  output logic       rx_enable,
  output logic       lsi_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(OSR * 12 + 1);
  localparam int HALF = OSR / 2;
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  // break detector
  logic [TW-1:0] frame_ticks, low_cnt, hi_cnt;
  logic          brk_hold, brk_evt;

  assign frame_ticks = TW'(OSR * (7 + int'(word_len) + int'(parity_en) + int'(stop2)));
  assign brk_evt     = tick16 & ~rxd & ~brk_hold & (low_cnt == frame_ticks);
  assign rx_enable   = ~brk_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      hi_cnt   <= '0;
      brk_hold <= 1'b0;
    end else if (tick16) begin
      if (brk_hold) begin
        low_cnt <= '0;
        if (!rxd) hi_cnt <= '0;
        else if (hi_cnt == TW'(HALF - 1)) begin
          hi_cnt   <= '0;
          brk_hold <= 1'b0;
        end else hi_cnt <= hi_cnt + TW'(1);
      end else if (!rxd) begin
        if (brk_evt) begin
          low_cnt  <= '0;
          brk_hold <= 1'b1;
        end else low_cnt <= low_cnt + TW'(1);
      end else low_cnt <= '0;
    end
  end

  // receive store: entry = {bi, fe, pe, data}
  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, err_cnt, err_nxt;
  logic          head_ack, oe;
  logic [10:0]   push_word, head;
  logic          push, pop, full, overflow, do_write, overwrite, new_head;

  assign push      = brk_evt | (rx_char_valid & ~brk_hold);
  assign push_word = brk_evt ? 11'h400 : {1'b0, rx_ferr, rx_perr, rx_char_data};
  assign head      = mem[rd_ptr];
  assign pop       = rx_pop & (cnt != '0);
  assign full      = fifo_mode ? (cnt == FULL_C) : (cnt != '0);
  assign overflow  = push & full & ~pop;
  assign overwrite = overflow & ~fifo_mode;
  assign do_write  = push & (~full | pop);
  assign new_head  = pop | (do_write & (cnt == '0)) | overwrite;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    err_nxt = err_cnt;
    if (do_write && |push_word[10:8]) err_nxt = err_nxt + CW'(1);
    if (pop && |head[10:8])           err_nxt = err_nxt - CW'(1);
    if (overwrite) begin
      if (|head[10:8])      err_nxt = err_nxt - CW'(1);
      if (|push_word[10:8]) err_nxt = err_nxt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (overwrite)     mem[rd_ptr] <= push_word;
    else if (do_write) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
      err_cnt  <= '0;
      head_ack <= 1'b0;
      oe       <= 1'b0;
    end else begin
      if (do_write) wr_ptr <= inc(wr_ptr);
      if (pop)      rd_ptr <= inc(rd_ptr);
      cnt      <= cnt + CW'(do_write) - CW'(pop);
      err_cnt  <= err_nxt;
      head_ack <= new_head ? 1'b0 : (lsr_rd | head_ack);
      oe       <= overflow | (oe & ~lsr_rd);
    end
  end

  // transmit occupancy
  logic [CW-1:0] tx_cnt;
  logic          tsr_busy, load_ok, wr_ok;

  assign load_ok = tsr_load & (tx_cnt != '0);
  assign wr_ok   = thr_wr & ((tx_cnt != (fifo_mode ? FULL_C : CW'(1))) | load_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt   <= '0;
      tsr_busy <= 1'b0;
    end else begin
      tx_cnt <= tx_cnt + CW'(wr_ok) - CW'(load_ok);
      if (load_ok)       tsr_busy <= 1'b1;
      else if (tsr_done) tsr_busy <= 1'b0;
    end
  end

  // status word
  logic [2:0] head_err;
  assign head_err     = head[10:8] & {3{(cnt != '0) & ~head_ack}};
  assign lsr          = {fifo_mode & (err_cnt != '0), (tx_cnt == '0) & ~tsr_busy,
                         tx_cnt == '0, head_err, oe, cnt != '0};
  assign rx_head_data = (cnt != '0) ? head[7:0] : 8'h00;
  assign lsi_irq      = lsi_en & |lsr[4:1];
endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxd,
  input logic       rx_enable,
  input logic [7:0] lsr,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic       tsr_load
);
  p_brk_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_enable) |-> lsr[0]);

  p_recover_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_enable) |-> $past(rxd));

  p_oe_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[1] && !lsr_rd) |=> lsr[1]);

  p_thre_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !lsr[5]);

  p_temt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tsr_load && !lsr[5]) |=> !lsr[6]);

  p_summary_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> !lsr[7]);
endmodule

bind uart_line_status uart_line_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_enable(rx_enable), .lsr(lsr),
  .lsr_rd(lsr_rd), .thr_wr(thr_wr), .tsr_load(tsr_load)
);

// File: tb/tb_uart_line_status.sv
module tb_uart_line_status;
  logic clk = 0, rst_n = 0, fifo_mode = 1, tick16 = 1, rxd = 1;
  logic [1:0] word_len = 2'd3;
  logic parity_en = 0, stop2 = 0, rx_char_valid = 0, rx_perr = 0, rx_ferr = 0;
  logic [7:0] rx_char_data = 0;
  logic rx_pop = 0, lsr_rd = 0, thr_wr = 0, tsr_load = 0, tsr_done = 0, lsi_en = 1;
  logic [7:0] lsr, rx_head_data;
  logic rx_enable, lsi_irq;
  int n_run = 0, n_fail = 0;
  logic [10:0] exp_q[$];

  always #5 clk = ~clk;

  uart_line_status dut (.*);

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_char(logic [7:0] d, logic pe, logic fe, bit accepted);
    rx_char_valid = 1; rx_char_data = d; rx_perr = pe; rx_ferr = fe;
    step();
    rx_char_valid = 0; rx_perr = 0; rx_ferr = 0;
    if (accepted) exp_q.push_back({1'b0, fe, pe, d});
  endtask

  task automatic pulse_rd();
    lsr_rd = 1; step(); lsr_rd = 0;
  endtask

  // monitor side: compare head against scoreboard front, then pop
  task automatic pop_check(string req, logic [2:0] errmask);
    logic [10:0] e;
    e = exp_q.pop_front();
    chk(rx_head_data == e[7:0], req, rx_head_data, e[7:0]);
    chk(lsr[4:2] == (e[10:8] & errmask), req, lsr[4:2], e[10:8] & errmask);
    rx_pop = 1; step(); rx_pop = 0;
  endtask

  task automatic break_run(int frame, string tag);
    rxd = 0;
    step(frame);
    chk(lsr[0] == 0, {tag, " no push at F ticks"}, lsr[0], 0);
    step();
    chk(lsr[0] == 1 && lsr[4] == 1, {tag, " break at F+1"}, lsr[4:0], 5'h11);
    chk(rx_enable == 0, {tag, " rx held"}, rx_enable, 0);
    exp_q.push_back(11'h400);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R12 reset state
    chk(lsr == 8'h60, "R12 reset lsr", lsr, 8'h60);
    chk(rx_enable == 1 && lsi_irq == 0 && rx_head_data == 0, "R12 reset outputs",
        {rx_enable, lsi_irq, rx_head_data}, 10'h200);

    // R4 R10 R11: tags follow characters in queued mode
    push_char(8'hA5, 0, 0, 1);
    push_char(8'h3C, 1, 0, 1);
    push_char(8'h7E, 0, 1, 1);
    chk(lsr[0] == 1 && lsr[7] == 1, "R10 summary set, R12 ready", {lsr[7], lsr[0]}, 2'b11);
    chk(lsi_irq == 0, "R11 clean head no irq", lsi_irq, 0);
    pop_check("R4 clean head", 3'b111);
    chk(lsr[2] == 1 && lsi_irq == 1, "R11 parity head irq", {lsr[2], lsi_irq}, 2'b11);
    pulse_rd();
    chk(lsr[2] == 0 && lsr[7] == 1, "R5 R10 read hides head, summary stays",
        {lsr[7], lsr[2]}, 2'b10);
    chk(lsi_irq == 0, "R11 irq drops after read", lsi_irq, 0);
    pop_check("R5 acked parity head", 3'b000);
    pop_check("R4 framing head", 3'b111);
    chk(lsr[7] == 0 && lsr[0] == 0, "R10 R12 empty clears", {lsr[7], lsr[0]}, 0);

    // R6: read in same cycle as new errored head
    lsr_rd = 1; push_char(8'h55, 1, 0, 1); lsr_rd = 0;
    chk(lsr[2] == 1, "R6 new tag survives read", lsr[2], 1);
    pop_check("R6 pop", 3'b111);

    // R7 queued overrun discards
    for (int i = 0; i < 17; i++) push_char(8'(i + 16), 0, 0, i < 16);
    chk(lsr[1] == 1 && lsi_irq == 1, "R7 overrun flag", {lsr[1], lsi_irq}, 2'b11);
    pulse_rd();
    chk(lsr[1] == 0, "R5 read clears overrun", lsr[1], 0);
    lsr_rd = 1; push_char(8'hEE, 0, 0, 0); lsr_rd = 0;
    chk(lsr[1] == 1, "R6 overrun kept on same-cycle read", lsr[1], 1);
    while (exp_q.size() > 0) pop_check("R7 queued data kept", 3'b111);
    chk(lsr[0] == 0, "R7 only 16 stored", lsr[0], 0);
    pulse_rd();

    // R7 R10 legacy mode overwrite
    fifo_mode = 0;
    push_char(8'h11, 1, 0, 1);
    chk(lsr[2] == 1 && lsr[7] == 0, "R10 legacy summary zero", {lsr[7], lsr[2]}, 2'b01);
    void'(exp_q.pop_back());
    push_char(8'h22, 0, 0, 1);
    chk(lsr[1] == 1, "R7 legacy overrun", lsr[1], 1);
    pop_check("R7 legacy overwrite", 3'b111);
    pulse_rd();

    // R8 R9 legacy transmit
    thr_wr = 1; step(); thr_wr = 0;
    chk(lsr[6:5] == 2'b00, "R8 R9 write clears", lsr[6:5], 0);
    tsr_load = 1; step(); tsr_load = 0;
    chk(lsr[6:5] == 2'b01, "R8 load sets thre, R9 temt low", lsr[6:5], 2'b01);
    tsr_done = 1; step(); tsr_done = 0;
    chk(lsr[6:5] == 2'b11, "R9 temt after done", lsr[6:5], 2'b11);

    // R8 R9 queued transmit
    fifo_mode = 1;
    thr_wr = 1; step(3); thr_wr = 0;
    tsr_load = 1; step(); tsr_load = 0;
    chk(lsr[5] == 0, "R8 bytes remain", lsr[5], 0);
    tsr_load = 1; step(2); tsr_load = 0;
    chk(lsr[6:5] == 2'b01, "R8 empty store, R9 shifter busy", lsr[6:5], 2'b01);
    tsr_done = 1; step(); tsr_done = 0;
    chk(lsr[6:5] == 2'b11, "R9 all empty", lsr[6:5], 2'b11);

    // R1 R2 R3 break with 8N1 (F = 160)
    break_run(160, "R1 8N1");
    step(300);
    push_char(8'h99, 0, 0, 0);
    pulse_rd();
    chk(lsr[4] == 0, "R5 read clears break", lsr[4], 0);
    pop_check("R2 single zero char", 3'b000);
    chk(lsr[0] == 0, "R2 R3 one char only", lsr[0], 0);
    rxd = 1; step(5); rxd = 0; step(); rxd = 1;
    step(7);
    chk(rx_enable == 0, "R3 glitch restarts idle count", rx_enable, 0);
    step();
    chk(rx_enable == 1, "R3 resumes after 8 high ticks", rx_enable, 1);
    push_char(8'h42, 0, 0, 1);
    pop_check("R3 reception resumed", 3'b111);

    // R1 break with 5 bits, parity, 2 stop (F = 144), interrupt masked
    word_len = 0; parity_en = 1; stop2 = 1; lsi_en = 0;
    break_run(144, "R1 5P2");
    chk(lsi_irq == 0, "R11 masked", lsi_irq, 0);
    lsi_en = 1; step();
    chk(lsi_irq == 1, "R11 enabled break irq", lsi_irq, 1);
    rxd = 1; step(8);
    chk(rx_enable == 1, "R3 recovery second frame", rx_enable, 1);
    pop_check("R2 R4 break tag at head", 3'b111);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule